// File: doc/BRIEF.md
# Synchronous Clock Output Stopper

This block sits between a clock synthesizer and its output pins and decides, for each of a group of generated clocks, whether that clock reaches its pin. Each lane runs only when its enable bit from the control registers is set and the shared active-low stop pin does not hold it. A parameter mask marks which lanes obey the stop pin. A typical mask covers the processor clocks, so that the other clocks and the oscillator keep running while those lanes are held.

Every start or stop request is first captured on a rising edge of the free-running reference clock. It is then passed through a synchronizer clocked by the lane's own target clock. It takes effect on the next falling edge of that target clock. A lane therefore changes state only while its target clock is low. A stopped lane rests low, and every high phase it delivers, including the last one before a stop and the first one after a restart, is full width. Clearing a register enable bit also forces the lane low at once, without waiting for the synchronizer. This direct path may shorten the high phase in progress. A pin-function bit disables the stop pin entirely when the shared pin is used for another purpose.

Top module: `clk_stopper`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` is 0.
- R2: With `reg_en[i]`=1 and lane i not held by the stop pin, `clk_out[i]` follows `tgt_clk[i]`: one rising edge per target period, each high phase as wide as the target's.
- R3: With `pin_mode`=0 and `stop_n`=0, every lane whose `STOP_MASK` bit is 1 ends low and makes no further rising edge.
- R4: A lane whose `STOP_MASK` bit is 0 ignores `stop_n` and keeps running. The defaults are 6 lanes and `STOP_MASK`=6'b001111, so lanes 4 and 5 are free.
- R5: With `pin_mode`=1, `stop_n` has no effect on any lane.
- R6: A stop request is captured on a rising edge of `ref_clk`, then passes `SYNC_STAGES` rising edges of the target clock, then applies at the next falling edge of that clock. A lane therefore still makes at least `SYNC_STAGES` (default 2) rising edges after `stop_n` falls.
- R7: Apart from the forced path of R9, every high phase and every low phase of `clk_out[i]` lasts at least one target half period. This covers the last pulse before a stop and the first pulse after a restart.
- R8: The internal run/stop state of a lane changes only while its target clock is low.
- R9: Clearing `reg_en[i]` (1 = enabled, 0 = stopped) drives `clk_out[i]` to 0 in the same time step, even in mid high phase, and the lane stays low regardless of its `STOP_MASK` bit.
- R10: Setting `reg_en[i]` back to 1 does not restart the lane at once. The restart goes through the synchronized path and begins with a full high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock that captures requests |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_clk | input | NUM_CLK | Target clocks to be gated, one per lane |
| reg_en | input | NUM_CLK | Register enable per lane, 1 = run |
| stop_n | input | 1 | Active-low stop pin for the masked lanes |
| pin_mode | input | 1 | 0 = shared pin acts as stop pin, 1 = stop pin ignored |
| clk_out | output | NUM_CLK | Gated clock outputs |

## Verification
On every cycle, the assertions check that a lane's run/stop state moves only while its target clock is low. They also check that an output falls only with its target clock or with a forced disable, and that the captured request follows the enable bit, the stop pin, the pin mode and the mask. The bench's scenarios are the only place where the following can be seen: the measured widths of the last and first pulses around a stop, the number of pulses that still pass after the stop pin falls, the immediate drop of a lane when its enable is cleared in mid high phase, and the fact that re-enabling does not restart the lane at once.

// File: rtl/cstop_pkg.sv
`timescale 1ns/1ps
package cstop_pkg;

   // function of the shared control pin
   typedef enum logic {
      PINF_STOP  = 1'b0,
      PINF_OTHER = 1'b1
   } pin_fn_e;

   localparam int MIN_SYNC_STAGES = 2;

   // run decision of one lane before synchronization
   function automatic logic lane_allow(input logic en,
                                       input logic stoppable,
                                       input logic pin_fn,
                                       input logic stop_n);
      logic pin_hold;
      pin_hold = stoppable && (pin_fn_e'(pin_fn) == PINF_STOP) && !stop_n;
      return en && !pin_hold;
   endfunction

endpackage

// File: rtl/cstop_sync.sv
`timescale 1ns/1ps
module cstop_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cstop_req_capture.sv
`timescale 1ns/1ps
module cstop_req_capture #(
   parameter int                 NUM_CLK   = 6,
   parameter logic [NUM_CLK-1:0] STOP_MASK = '1
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic [NUM_CLK-1:0] reg_en,
   input  logic               stop_n,
   input  logic               pin_mode,
   output logic [NUM_CLK-1:0] req_q
);
   logic [NUM_CLK-1:0] allow;

   for (genvar i = 0; i < NUM_CLK; i++) begin : g_allow
      assign allow[i] = cstop_pkg::lane_allow(reg_en[i], STOP_MASK[i], pin_mode, stop_n);
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= allow;
   end
endmodule

// File: rtl/cstop_lane_gate.sv
`timescale 1ns/1ps
module cstop_lane_gate #(
   parameter int SYNC_STAGES = 2,
   parameter bit FORCE_ASYNC = 1'b1
) (
   input  logic tgt_clk,
   input  logic rst_n,
   input  logic req_async,
   input  logic reg_en,
   output logic gate_q,
   output logic clk_out
);
   logic req_sync;

   cstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (tgt_clk),
      .rst_n (rst_n),
      .d     (req_async),
      .q     (req_sync)
   );

   // run state moves only at a falling edge, while the clock is low
   always_ff @(negedge tgt_clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= req_sync;
   end

   if (FORCE_ASYNC) begin : g_forced
      assign clk_out = tgt_clk & gate_q & reg_en;
   end else begin : g_sync_only
      assign clk_out = tgt_clk & gate_q;
   end
endmodule

// File: rtl/clk_stopper.sv
`timescale 1ns/1ps
module clk_stopper #(
   parameter int                 NUM_CLK     = 6,
   parameter logic [NUM_CLK-1:0] STOP_MASK   = 6'b001111,
   parameter int                 SYNC_STAGES = 2,
   parameter bit                 FORCE_ASYNC = 1'b1
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic [NUM_CLK-1:0] tgt_clk,
   input  logic [NUM_CLK-1:0] reg_en,
   input  logic               stop_n,
   input  logic               pin_mode,
   output logic [NUM_CLK-1:0] clk_out
);
   localparam int LANE_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1;

   if (NUM_CLK < 1 || LANE_W > 8) begin : g_bad_count
      $error("clk_stopper: NUM_CLK out of range");
   end
   if (SYNC_STAGES < cstop_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
      $error("clk_stopper: SYNC_STAGES below minimum");
   end

   logic [NUM_CLK-1:0] req_q;
   logic [NUM_CLK-1:0] gate_q;

   cstop_req_capture #(
      .NUM_CLK   (NUM_CLK),
      .STOP_MASK (STOP_MASK)
   ) u_capture (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .reg_en   (reg_en),
      .stop_n   (stop_n),
      .pin_mode (pin_mode),
      .req_q    (req_q)
   );

   for (genvar i = 0; i < NUM_CLK; i++) begin : g_lane
      cstop_lane_gate #(
         .SYNC_STAGES (SYNC_STAGES),
         .FORCE_ASYNC (FORCE_ASYNC)
      ) u_gate (
         .tgt_clk   (tgt_clk[i]),
         .rst_n     (rst_n),
         .req_async (req_q[i]),
         .reg_en    (reg_en[i]),
         .gate_q    (gate_q[i]),
         .clk_out   (clk_out[i])
      );
   end
endmodule

// File: rtl/clk_stopper_chk.sv
`timescale 1ns/1ps
module clk_stopper_chk #(
   parameter int                 NUM_CLK   = 6,
   parameter logic [NUM_CLK-1:0] STOP_MASK = 6'b001111
) (
   input logic               ref_clk,
   input logic               rst_n,
   input logic [NUM_CLK-1:0] tgt_clk,
   input logic [NUM_CLK-1:0] reg_en,
   input logic               stop_n,
   input logic               pin_mode,
   input logic [NUM_CLK-1:0] clk_out,
   input logic [NUM_CLK-1:0] req_q,
   input logic [NUM_CLK-1:0] gate_q
);
   for (genvar i = 0; i < NUM_CLK; i++) begin : g_chk
      // R8
      always @(gate_q[i]) begin
         if (rst_n) begin
            gate_low_phase_chk: assert (!tgt_clk[i]);
         end
      end

      // R7
      always @(negedge clk_out[i]) begin
         if (rst_n) begin
            full_high_chk: assert (!tgt_clk[i] || !reg_en[i]);
         end
      end

      // R5
      mode_ignores_pin_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
         (pin_mode && reg_en[i]) |=> req_q[i]);

      // R9
      reg_off_req_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
         !reg_en[i] |=> !req_q[i]);

      if (STOP_MASK[i]) begin : g_held
         // R3
         pin_stop_req_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
            (!pin_mode && !stop_n) |=> !req_q[i]);
      end else begin : g_free
         // R4
         free_lane_req_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
            reg_en[i] |=> req_q[i]);
      end
   end
endmodule

bind clk_stopper clk_stopper_chk #(
   .NUM_CLK   (NUM_CLK),
   .STOP_MASK (STOP_MASK)
) u_chk (
   .ref_clk  (ref_clk),
   .rst_n    (rst_n),
   .tgt_clk  (tgt_clk),
   .reg_en   (reg_en),
   .stop_n   (stop_n),
   .pin_mode (pin_mode),
   .clk_out  (clk_out),
   .req_q    (req_q),
   .gate_q   (gate_q)
);

// File: tb/clk_stopper_tb.sv
`timescale 1ns/1ps
module clk_stopper_tb;
   localparam int N = 6;
   localparam logic [N-1:0] MASK = 6'b001111;

   logic         ref_clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] reg_en = '1;
   logic         stop_n = 1'b1;
   logic         pin_mode = 1'b0;
   wire  [N-1:0] tgt;
   wire  [N-1:0] clk_out;

   int n_checks = 0;
   int n_errors = 0;

   always #2 ref_clk = ~ref_clk;

   for (genvar i = 0; i < N; i++) begin : g_tgt
      localparam real HALF = 3.0 + 0.5 * i;
      localparam real OFF  = 0.3 + 0.1 * i;
      logic c;
      initial begin
         c = 1'b0;
         #(OFF);
         forever begin
            c = ~c;
            #(HALF);
         end
      end
      assign tgt[i] = c;
   end

   clk_stopper u_dut (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .tgt_clk  (tgt),
      .reg_en   (reg_en),
      .stop_n   (stop_n),
      .pin_mode (pin_mode),
      .clk_out  (clk_out)
   );

   function automatic real half_of(input int i);
      return 3.0 + 0.5 * i;
   endfunction

   // pulse monitor: counts rising edges and phases shorter than a half period
   logic [N-1:0] prev_out = '0;
   logic [N-1:0] async_ok = '0;
   real t_rise [N];
   real t_fall [N];
   int  rise_cnt [N];
   int  runt_cnt = 0;

   initial begin
      for (int i = 0; i < N; i++) begin
         t_rise[i] = -1.0;
         t_fall[i] = -1.0;
         rise_cnt[i] = 0;
      end
   end

   always @(clk_out) begin
      for (int i = 0; i < N; i++) begin
         if (clk_out[i] !== prev_out[i]) begin
            if (clk_out[i]) begin
               rise_cnt[i]++;
               if (rst_n && t_fall[i] >= 0.0 && ($realtime - t_fall[i]) < half_of(i) - 0.01)
                  runt_cnt++;
               t_rise[i] = $realtime;
            end else begin
               if (rst_n && !async_ok[i] && t_rise[i] >= 0.0) begin
                  if (($realtime - t_rise[i]) < half_of(i) - 0.01 ||
                      ($realtime - t_rise[i]) > half_of(i) + 0.01)
                     runt_cnt++;
               end
               t_fall[i] = $realtime;
            end
         end
      end
      prev_out = clk_out;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // number of rising edges expected in a window, allowing one boundary edge
   task automatic check_rate(input string req, input int lane, input int act, input real win);
      int e;
      e = $rtoi(win / (2.0 * half_of(lane)));
      check(act == e || act == e + 1, req, $sformatf("lane %0d edge count", lane), act, e);
   endtask

   task automatic t_reset();
      int bad;
      bad = 0;
      rst_n = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge ref_clk);
         if (clk_out !== '0) bad++;
      end
      check(bad == 0, "R1", "outputs low in reset", bad, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_run();
      int s0 [N];
      int r0;
      r0 = runt_cnt;
      #80;
      for (int i = 0; i < N; i++) s0[i] = rise_cnt[i];
      #120;
      for (int i = 0; i < N; i++) check_rate("R2", i, rise_cnt[i] - s0[i], 120.0);
      check(runt_cnt == r0, "R7", "short phases while running", runt_cnt - r0, 0);
   endtask

   task automatic t_stop();
      int s0 [N];
      int s1 [N];
      int r0;
      r0 = runt_cnt;
      @(negedge ref_clk);
      for (int i = 0; i < N; i++) s0[i] = rise_cnt[i];
      stop_n = 1'b0;
      #80;
      for (int i = 0; i < N; i++) begin
         if (MASK[i]) begin
            check(rise_cnt[i] - s0[i] >= 2, "R6", $sformatf("lane %0d edges after stop", i),
                  rise_cnt[i] - s0[i], 2);
            check(clk_out[i] == 1'b0, "R3", $sformatf("lane %0d rests low", i), clk_out[i], 0);
         end
         s1[i] = rise_cnt[i];
      end
      #100;
      for (int i = 0; i < N; i++) begin
         if (MASK[i])
            check(rise_cnt[i] == s1[i], "R3", $sformatf("lane %0d no edges", i),
                  rise_cnt[i] - s1[i], 0);
         else
            check_rate("R4", i, rise_cnt[i] - s0[i], 180.0);
      end
      check(runt_cnt == r0, "R7", "short phases around stop", runt_cnt - r0, 0);
   endtask

   task automatic t_restart();
      int s0 [N];
      int r0;
      r0 = runt_cnt;
      @(negedge ref_clk);
      stop_n = 1'b1;
      #80;
      for (int i = 0; i < N; i++) s0[i] = rise_cnt[i];
      #120;
      for (int i = 0; i < N; i++) check_rate("R2", i, rise_cnt[i] - s0[i], 120.0);
      check(runt_cnt == r0, "R7", "short phases around restart", runt_cnt - r0, 0);
   endtask

   task automatic t_mode();
      int s0 [N];
      int r0;
      r0 = runt_cnt;
      @(negedge ref_clk);
      pin_mode = 1'b1;
      #8;
      for (int i = 0; i < N; i++) s0[i] = rise_cnt[i];
      stop_n = 1'b0;
      #120;
      for (int i = 0; i < N; i++) check_rate("R5", i, rise_cnt[i] - s0[i], 120.0);
      stop_n = 1'b1;
      #8;
      @(negedge ref_clk);
      pin_mode = 1'b0;
      check(runt_cnt == r0, "R7", "short phases in other pin mode", runt_cnt - r0, 0);
   endtask

   task automatic t_async(input int lane);
      int s0;
      int r0;
      r0 = runt_cnt;
      @(posedge tgt[lane]);
      #0.5;
      check(clk_out[lane] == 1'b1, "R2", $sformatf("lane %0d high before disable", lane),
            clk_out[lane], 1);
      async_ok[lane] = 1'b1;
      reg_en[lane] = 1'b0;
      #0.2;
      check(clk_out[lane] == 1'b0, "R9", $sformatf("lane %0d forced low", lane), clk_out[lane], 0);
      #60;
      s0 = rise_cnt[lane];
      #60;
      check(rise_cnt[lane] == s0, "R9", $sformatf("lane %0d stays stopped", lane),
            rise_cnt[lane] - s0, 0);
      @(posedge tgt[lane]);
      #0.5;
      reg_en[lane] = 1'b1;
      #0.2;
      check(clk_out[lane] == 1'b0, "R10", $sformatf("lane %0d no instant restart", lane),
            clk_out[lane], 0);
      async_ok[lane] = 1'b0;
      #80;
      s0 = rise_cnt[lane];
      #120;
      check_rate("R10", lane, rise_cnt[lane] - s0, 120.0);
      check(runt_cnt == r0, "R7", $sformatf("lane %0d short phases after re-enable", lane),
            runt_cnt - r0, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      #800000;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_run();
      t_stop();
      t_restart();
      t_mode();
      t_async(1);
      t_async(5);
      t_run();
      finish_run();
   end
endmodule